// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the processor-facing side of a three-channel interval timer. It takes an 8-bit data bus, a 2-bit address and separate read and write strobes. Addresses 0, 1 and 2 reach the data registers of the three channels. Address 3 takes control words. The counting logic is outside this block. Each channel gets a one-cycle load pulse with a 16-bit start value, plus its programmed mode and its binary/BCD flag. In return each channel reports its live count, the level of its output and a pulse when it has taken a loaded value into its counting element.

A control word does one of three things. It programs a channel's access format, mode and number base. It freezes a snapshot of one channel's count. Or it issues a read-back that snapshots count, status or both for any set of channels at once. Each channel holds its own low/high byte toggles for writes and for reads. A snapshot stays held until it has been fully read out. The status byte reports the output level, a null-count flag and the programmed fields.

Top module: `ivt_host_port`

## Requirements
- R1: A control-word write has bits 7:6 = channel number 0..2, bits 5:4 ≠ 00, bits 3:1 = mode and bit 0 = BCD flag. It updates that channel's mode and BCD outputs one clock after the write edge. After reset every channel has mode 000, BCD 0, access format 11 and null-count set.
- R2: In format 10 (low byte only), a data write of b loads {8'h00,b}. In format 01 (high byte only), it loads {b,8'h00}. The load pulse and value appear for one cycle after the write edge.
- R3: In format 11, the first data write supplies the low byte and produces no load. The second write supplies the high byte and loads {high,low}.
- R4: A control word that programs a channel resets that channel's write toggle and read toggle.
- R5: With nothing latched, a read returns the live count. Format 01 returns the high byte, format 10 the low byte, and format 11 alternates low then high.
- R6: A control word with bits 5:4 = 00 snapshots the selected channel's count and leaves its mode and format unchanged. Reads return the snapshot in the programmed format until it has been fully read, then return to the live count.
- R7: While a count snapshot or a status snapshot is held, further count or status latch requests for that channel are ignored.
- R8: A read-back command has bits 7:6 = 11. Bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2. Bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch. The command is ignored entirely when bit 0 is 1, and unselected channels are untouched.
- R9: The status byte is {OUT, null, format[1:0], mode[2:0], BCD}. When a channel has both a status and a count snapshot, the first read returns the status and later reads return the count.
- R10: The null-count flag is set by a programming control word and by every count load. It is cleared by the channel's taken pulse.
- R11: A read at address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 2 | 0..2 channel data, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, valid while rd_en is high |
| cnt_live | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| out_lvl | input | 3 | Output level of each channel |
| cnt_taken | input | 3 | Channel has moved the loaded value into its counter |
| ld_stb | output | 3 | One-cycle load pulse per channel |
| ld_val | output | 48 | Value to load, 16 bits per channel |
| ch_mode | output | 9 | Programmed mode, 3 bits per channel |
| ch_bcd | output | 3 | Programmed BCD flag per channel |

## Verification
The hardest case to reach is a channel that holds a status snapshot and a count snapshot together while the live inputs and the output level move underneath them. From the ports it shows only as the order and values of later reads. The bench programs two channels with different formats and issues one read-back for both. It then changes every live count and output level, repeats the latch requests, and reads each channel through status, snapshot bytes and back to live data. It also sweeps every channel, format, mode and base through status read-back, and every channel and format through loads and live reads.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int MW = 3;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'b00,
    FMT_HI    = 2'b01,
    FMT_LO    = 2'b10,
    FMT_BOTH  = 2'b11
  } fmt_e;
endpackage

// File: rtl/ivt_cw_decode.sv
module ivt_cw_decode #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [NCH-1:0]    prog,
  output logic [NCH-1:0]    lat_cnt,
  output logic [NCH-1:0]    lat_st,
  output logic [NCH-1:0]    wr_stb,
  output logic [NCH-1:0]    rd_stb
);
  logic       is_ctl;
  logic       is_rb;
  logic [1:0] sel;
  logic [1:0] fmt;

  assign is_ctl = wr_en && (addr == 2'd3);
  assign sel    = wdata[7:6];
  assign fmt    = wdata[5:4];
  assign is_rb  = (sel == 2'd3);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic rb_hit;
    assign hit        = is_ctl && !is_rb && (sel == 2'(c));
    assign rb_hit     = is_ctl && is_rb && !wdata[0] && wdata[c+1];
    assign prog[c]    = hit && (fmt != 2'b00);
    assign lat_cnt[c] = (hit && (fmt == 2'b00)) || (rb_hit && !wdata[5]);
    assign lat_st[c]  = rb_hit && !wdata[4];
    assign wr_stb[c]  = wr_en && (addr == 2'(c));
    assign rd_stb[c]  = rd_en && !wr_en && (addr == 2'(c));
  end

  AST_RB_BIT0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && is_rb && wdata[0]) |-> (lat_cnt == '0 && lat_st == '0 && prog == '0)) else $error("rb bit0"); // R8
endmodule

// File: rtl/ivt_chan_regs.sv
module ivt_chan_regs
  import ivt_pkg::*;
#(
  parameter int DW = 8,
  parameter int MW = 3,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  fmt_e          prog_fmt,
  input  logic [MW-1:0] prog_mode,
  input  logic          prog_bcd,
  input  logic          lat_cnt,
  input  logic          lat_st,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_stb,
  input  logic [CW-1:0] live,
  input  logic          out_lvl,
  input  logic          taken,
  output logic [DW-1:0] rd_byte,
  output logic          ld_stb,
  output logic [CW-1:0] ld_val,
  output logic [MW-1:0] mode,
  output logic          bcd
);
  fmt_e          fmt_q, fmt_d;
  logic [MW-1:0] mode_q, mode_d;
  logic          bcd_q, bcd_d, null_q, null_d;
  logic          wtog_q, wtog_d, rtog_q, rtog_d;
  logic [DW-1:0] wlo_q, wlo_d;
  logic          cl_q, cl_d, sl_q, sl_d;
  logic [CW-1:0] cv_q, cv_d;
  logic [DW-1:0] sv_q, sv_d, stat_now;
  logic          ld_q, ld_d;
  logic [CW-1:0] lv_q, lv_d;
  logic          commit;
  logic [CW-1:0] cval;
  logic [CW-1:0] src;
  logic          hi_sel;

  assign stat_now = {out_lvl, null_q, fmt_q, mode_q, bcd_q};
  assign src      = cl_q ? cv_q : live;
  assign hi_sel   = (fmt_q == FMT_HI) || ((fmt_q == FMT_BOTH) && rtog_q);
  assign rd_byte  = sl_q ? sv_q : (hi_sel ? src[CW-1:DW] : src[DW-1:0]);

  always_comb begin
    fmt_d  = fmt_q;  mode_d = mode_q; bcd_d = bcd_q; null_d = null_q;
    wtog_d = wtog_q; wlo_d  = wlo_q;  rtog_d = rtog_q;
    cl_d   = cl_q;   cv_d   = cv_q;   sl_d  = sl_q;  sv_d = sv_q;
    ld_d   = 1'b0;   lv_d   = lv_q;
    commit = 1'b0;   cval   = '0;
    if (wr_stb) begin
      case (fmt_q)
        FMT_HI: begin commit = 1'b1; cval = {wr_byte, {DW{1'b0}}}; end
        FMT_LO: begin commit = 1'b1; cval = {{DW{1'b0}}, wr_byte}; end
        FMT_BOTH: begin
          if (wtog_q) begin
            commit = 1'b1; cval = {wr_byte, wlo_q}; wtog_d = 1'b0;
          end else begin
            wlo_d = wr_byte; wtog_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (taken) null_d = 1'b0;
    if (commit) begin
      ld_d = 1'b1; lv_d = cval; null_d = 1'b1;
    end
    if (rd_stb) begin
      if (sl_q) begin
        sl_d = 1'b0;
      end else begin
        if (fmt_q == FMT_BOTH) rtog_d = !rtog_q;
        if (cl_q && ((fmt_q != FMT_BOTH) || rtog_q)) cl_d = 1'b0;
      end
    end
    if (lat_cnt && !cl_q) begin cl_d = 1'b1; cv_d = live; end
    if (lat_st && !sl_q) begin sl_d = 1'b1; sv_d = stat_now; end
    if (prog) begin
      fmt_d = prog_fmt; mode_d = prog_mode; bcd_d = prog_bcd;
      wtog_d = 1'b0; rtog_d = 1'b0; null_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_BOTH; mode_q <= '0; bcd_q <= 1'b0; null_q <= 1'b1;
      wtog_q <= 1'b0; wlo_q <= '0; rtog_q <= 1'b0;
      cl_q <= 1'b0; cv_q <= '0; sl_q <= 1'b0; sv_q <= '0;
      ld_q <= 1'b0; lv_q <= '0;
    end else begin
      fmt_q <= fmt_d; mode_q <= mode_d; bcd_q <= bcd_d; null_q <= null_d;
      wtog_q <= wtog_d; wlo_q <= wlo_d; rtog_q <= rtog_d;
      cl_q <= cl_d; cv_q <= cv_d; sl_q <= sl_d; sv_q <= sv_d;
      ld_q <= ld_d; lv_q <= lv_d;
    end
  end

  assign ld_stb = ld_q;
  assign ld_val = lv_q;
  assign mode   = mode_q;
  assign bcd    = bcd_q;

  AST_LD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> $past(wr_stb)) else $error("load without write"); // R2
  AST_NULL_ON_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> null_q) else $error("null not set"); // R10
  AST_TOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (!wtog_q && !rtog_q)) else $error("toggle not cleared"); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q && $past(cl_q)) |-> $stable(cv_q)) else $error("count snapshot moved"); // R7
  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_q && $past(sl_q)) |-> $stable(sv_q)) else $error("status snapshot moved"); // R7
endmodule

// File: rtl/ivt_host_port.sv
module ivt_host_port
  import ivt_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int MW  = 3,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*CW-1:0] cnt_live,
  input  logic [NCH-1:0]    out_lvl,
  input  logic [NCH-1:0]    cnt_taken,
  output logic [NCH-1:0]    ld_stb,
  output logic [NCH*CW-1:0] ld_val,
  output logic [NCH*MW-1:0] ch_mode,
  output logic [NCH-1:0]    ch_bcd
);
  logic [1:0]     rst_sync;
  logic           rst_q_n;
  logic [NCH-1:0] prog, lat_cnt, lat_st, wr_stb, rd_stb;
  logic [DW-1:0]  rd_byte [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  ivt_cw_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .prog(prog), .lat_cnt(lat_cnt), .lat_st(lat_st),
    .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ivt_chan_regs #(.DW(DW), .MW(MW)) u_ch (
      .clk(clk), .rst_n(rst_q_n), .prog(prog[c]), .prog_fmt(fmt_e'(wdata[5:4])),
      .prog_mode(wdata[MW:1]), .prog_bcd(wdata[0]), .lat_cnt(lat_cnt[c]),
      .lat_st(lat_st[c]), .wr_stb(wr_stb[c]), .wr_byte(wdata), .rd_stb(rd_stb[c]),
      .live(cnt_live[c*CW +: CW]), .out_lvl(out_lvl[c]), .taken(cnt_taken[c]),
      .rd_byte(rd_byte[c]), .ld_stb(ld_stb[c]), .ld_val(ld_val[c*CW +: CW]),
      .mode(ch_mode[c*MW +: MW]), .bcd(ch_bcd[c])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) rdata = rd_byte[i];
    end
  end

  AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && addr == 2'd3) |-> (rdata == '0)) else $error("ctl read"); // R11
endmodule

// File: tb/sim_ivt_host_port.sv
module sim_ivt_host_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [47:0] cnt_live;
  logic [2:0]  out_lvl, cnt_taken, ld_stb, ch_bcd;
  logic [47:0] ld_val;
  logic [8:0]  ch_mode;
  logic        cap_stb;
  logic [15:0] cap_val;
  int          n_run = 0, n_fail = 0;

  ivt_host_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_live(cnt_live), .out_lvl(out_lvl),
    .cnt_taken(cnt_taken), .ld_stb(ld_stb), .ld_val(ld_val),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  always #2 clk = !clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // write; the channel's load outputs are captured after the edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int ch);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cap_stb = ld_stb[ch]; cap_val = ld_val[ch*16 +: 16];
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic take(input int ch);
    @(negedge clk); cnt_taken[ch] = 1'b1;
    @(negedge clk); cnt_taken[ch] = 1'b0;
  endtask

  function automatic logic [7:0] rb_st(input int ch);
    return 8'hE0 | 8'(1 << (ch + 1));
  endfunction

  initial begin
    logic [7:0] v;
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    cnt_live = '0; out_lvl = '0; cnt_taken = '0; cap_stb = 0; cap_val = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state via status read-back of all channels
    chk("R1 reset mode", 32'(ch_mode), 32'h0);
    chk("R1 reset bcd", 32'(ch_bcd), 32'h0);
    wr(2'd3, 8'hEE, 0);
    for (int c = 0; c < 3; c++) begin
      rd(2'(c), v); chk("R1 R9 reset status", 32'(v), 32'h70);
    end

    // R1 R9 sweep: every channel, format, mode, base
    for (int c = 0; c < 3; c++)
      for (int f = 1; f < 4; f++)
        for (int m = 0; m < 6; m++)
          for (int b = 0; b < 2; b++) begin
            out_lvl[c] = m[0];
            wr(2'd3, {2'(c), 2'(f), 3'(m), 1'(b)}, c);
            chk("R1 mode", 32'(ch_mode[c*3 +: 3]), 32'(m));
            chk("R1 bcd", 32'(ch_bcd[c]), 32'(b));
            wr(2'd3, rb_st(c), c);
            rd(2'(c), v);
            chk("R9 status", 32'(v), 32'({m[0], 1'b1, 2'(f), 3'(m), 1'(b)}));
          end
    out_lvl = '0;

    // R2 R3 R5 R10 sweep: loads and live reads per format
    for (int c = 0; c < 3; c++)
      for (int f = 1; f < 4; f++)
        for (int i = 0; i < 4; i++) begin
          logic [15:0] val, lv;
          val = 16'((i * 16'h3A5B) ^ 16'hC08F);
          lv  = val ^ 16'h5A3C;
          wr(2'd3, {2'(c), 2'(f), 3'b010, 1'b0}, c);
          take(c);
          if (f == 3) begin
            wr(2'(c), val[7:0], c);
            chk("R3 no load after low", 32'(cap_stb), 32'h0);
            wr(2'(c), val[15:8], c);
            chk("R3 load", 32'(cap_stb), 32'h1);
            chk("R3 value", 32'(cap_val), 32'(val));
          end else begin
            wr(2'(c), val[7:0], c);
            chk("R2 load", 32'(cap_stb), 32'h1);
            chk("R2 value", 32'(cap_val), (f == 1) ? 32'({val[7:0], 8'h00}) : 32'({8'h00, val[7:0]}));
          end
          wr(2'd3, rb_st(c), c);
          rd(2'(c), v); chk("R10 null after load", 32'(v[6]), 32'h1);
          take(c);
          wr(2'd3, rb_st(c), c);
          rd(2'(c), v); chk("R10 null cleared", 32'(v[6]), 32'h0);
          cnt_live[c*16 +: 16] = lv;
          rd(2'(c), v);
          chk("R5 first read", 32'(v), (f == 1) ? 32'(lv[15:8]) : 32'(lv[7:0]));
          if (f == 3) begin
            rd(2'(c), v); chk("R5 second read", 32'(v), 32'(lv[15:8]));
          end
        end

    // R6 R7 count latch on channel 1, format 11
    wr(2'd3, 8'h74, 1);
    cnt_live[31:16] = 16'h1234;
    wr(2'd3, 8'h40, 1);
    cnt_live[31:16] = 16'h9999;
    wr(2'd3, 8'h40, 1);
    chk("R6 mode kept", 32'(ch_mode[5:3]), 32'h2);
    rd(2'd1, v); chk("R6 R7 latched low", 32'(v), 32'h34);
    rd(2'd1, v); chk("R6 R7 latched high", 32'(v), 32'h12);
    rd(2'd1, v); chk("R6 released", 32'(v), 32'h99);
    // R6 low-only format releases after one read
    wr(2'd3, 8'h64, 1);
    cnt_live[31:16] = 16'hABCD;
    wr(2'd3, 8'h40, 1);
    cnt_live[31:16] = 16'h1111;
    rd(2'd1, v); chk("R6 latched low only", 32'(v), 32'hCD);
    rd(2'd1, v); chk("R6 released low only", 32'(v), 32'h11);

    // R8 R9 combined read-back on channels 0 and 2
    wr(2'd3, 8'h37, 0);
    wr(2'd3, 8'hAA, 2);
    take(0); take(2);
    cnt_live = {16'h00EE, 16'h5555, 16'h4321};
    out_lvl = 3'b101;
    wr(2'd3, 8'hCA, 0);
    cnt_live = {16'h7777, 16'h5555, 16'hFFFF};
    out_lvl = 3'b000;
    wr(2'd3, 8'hCA, 0);
    rd(2'd0, v); chk("R9 ch0 status first", 32'(v), 32'hB7);
    rd(2'd0, v); chk("R8 ch0 count low", 32'(v), 32'h21);
    rd(2'd0, v); chk("R8 ch0 count high", 32'(v), 32'h43);
    rd(2'd0, v); chk("R8 ch0 live after", 32'(v), 32'hFF);
    rd(2'd2, v); chk("R9 ch2 status first", 32'(v), 32'hAA);
    rd(2'd2, v); chk("R8 ch2 count", 32'(v), 32'hEE);
    rd(2'd2, v); chk("R8 ch2 live after", 32'(v), 32'h77);
    rd(2'd1, v); chk("R8 ch1 unselected", 32'(v), 32'h55);

    // R8 bit 0 set: command ignored
    wr(2'd3, 8'h37, 0);
    wr(2'd3, 8'hCB, 0);
    cnt_live[15:0] = 16'h0102;
    rd(2'd0, v); chk("R8 bit0 ignored low", 32'(v), 32'h02);
    rd(2'd0, v); chk("R8 bit0 ignored high", 32'(v), 32'h01);

    // R7 repeated status latch ignored
    out_lvl[2] = 1'b1;
    wr(2'd3, 8'hE8, 2);
    out_lvl[2] = 1'b0;
    wr(2'd3, 8'hE8, 2);
    rd(2'd2, v); chk("R7 status held", 32'(v), 32'hAA);
    rd(2'd2, v); chk("R7 status released", 32'(v), 32'h77);

    // R4 reprogramming resets toggles
    wr(2'd3, 8'hB0, 2);
    wr(2'd2, 8'h11, 2);
    wr(2'd3, 8'hB0, 2);
    wr(2'd2, 8'h22, 2);
    chk("R4 write toggle reset", 32'(cap_stb), 32'h0);
    wr(2'd2, 8'h33, 2);
    chk("R4 value after reset", 32'(cap_val), 32'h3322);
    cnt_live[47:32] = 16'hBEEF;
    rd(2'd2, v); chk("R4 read low", 32'(v), 32'hEF);
    wr(2'd3, 8'hB0, 2);
    rd(2'd2, v); chk("R4 read toggle reset", 32'(v), 32'hEF);

    // R11 control address reads zero
    rd(2'd3, v); chk("R11 ctl read", 32'(v), 32'h0);

    summary();
  end
endmodule